// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block is the control logic of a 32-bit single-cycle load/store processor with 32 general registers. It is purely combinational. It reads the 6-bit primary opcode and the 6-bit function field of the current instruction. From them it produces every steering signal the datapath needs in that same cycle: destination register choice, second ALU operand choice, write-back source, register write enable, memory read and write enables, conditional branch and unconditional jump.

The decode works in two levels. A main opcode decoder recognises five instruction classes: register-format arithmetic, word load, word store, branch-if-equal and jump. It emits a 2-bit ALU class code. A second stage turns that class code, together with the function field, into a 3-bit ALU operation select. The function field only has an effect for register-format instructions. Any opcode outside the five classes leaves every write, memory and control-flow output inactive.

Top module: `insn_ctrl_decoder`

## Requirements
- R1: Opcode 000000 (register format) drives rd_dest=1, imm_operand=0, wb_from_mem=0, reg_wr_en=1, mem_rd_en=0, mem_wr_en=0, br_eq=0, jmp_take=0 and alu_class=10.
- R2: Opcode 100011 (load word) drives imm_operand=1, wb_from_mem=1, reg_wr_en=1 and mem_rd_en=1. It drives rd_dest, mem_wr_en, br_eq and jmp_take to 0, and alu_class=00.
- R3: Opcode 101011 (store word) drives imm_operand=1 and mem_wr_en=1. All other single-bit controls are 0, and alu_class=00.
- R4: Opcode 000100 (branch if equal) drives br_eq=1 and alu_class=01. All other single-bit controls are 0.
- R5: Opcode 000010 (jump) drives jmp_take=1. All other single-bit controls are 0, and alu_class=00.
- R6: Every other opcode drives all eight single-bit controls to 0 and alu_class=00.
- R7: When alu_class is 00 (or the unused 11), alu_op is 010 (add), whatever the function field holds.
- R8: When alu_class is 01, alu_op is 110 (subtract), whatever the function field holds.
- R9: For register format (alu_class 10), the function field selects alu_op as follows: 100100 gives 000 (and), 100101 gives 001 (or), 100000 gives 010 (add), 100010 gives 110 (subtract), 101010 gives 111 (set-less-than).
- R10: For register format, any function code not listed in R9 gives alu_op 010 (add).
- R11: imm_operand is 1 exactly when opcode bit 5 and bits 1 and 0 are 1 and bits 4 and 2 are 0; bit 3 does not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Primary opcode of the instruction |
| fn_code | input | 6 | Function field of the instruction |
| rd_dest | output | 1 | Write destination taken from the rd field (else rt) |
| imm_operand | output | 1 | ALU second operand is the sign-extended immediate |
| wb_from_mem | output | 1 | Register write-back data comes from data memory |
| reg_wr_en | output | 1 | Register file write enable |
| mem_rd_en | output | 1 | Data memory read enable |
| mem_wr_en | output | 1 | Data memory write enable |
| br_eq | output | 1 | Conditional branch on equality |
| jmp_take | output | 1 | Unconditional jump |
| alu_class | output | 2 | ALU class code passed to the second stage |
| alu_op | output | 3 | ALU operation select |

## Verification
Each of the five supported opcodes is applied with several function codes. This separates the opcode decode from the function-field decode and shows that the field is ignored outside register format. All 64 opcodes are then swept to confirm that only the five decoded ones raise any control, and that the immediate-operand output follows the stated bit equation. The register-format opcode is combined with the five listed function codes and with a spread of unlisted codes, including ones that differ from a listed code by one bit. This separates the exact function decode from the add fallback.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int CLS_W = 2;
  localparam int SEL_W = 3;

  localparam logic [OP_W-1:0] OPC_RFMT = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STOR = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JUMP = 6'b000010;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  localparam logic [SEL_W-1:0] SEL_AND = 3'b000;
  localparam logic [SEL_W-1:0] SEL_OR  = 3'b001;
  localparam logic [SEL_W-1:0] SEL_ADD = 3'b010;
  localparam logic [SEL_W-1:0] SEL_SUB = 3'b110;
  localparam logic [SEL_W-1:0] SEL_SLT = 3'b111;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10,
    CLS_RSVD  = 2'b11
  } alu_class_e;

  typedef struct packed {
    logic       rd_dest;
    logic       imm_op;
    logic       wb_mem;
    logic       reg_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       br;
    logic       jmp;
    alu_class_e cls;
  } ctrl_t;

  function automatic ctrl_t decode_opcode(input logic [OP_W-1:0] op);
    ctrl_t c;
    c = '{default: '0, cls: CLS_ADD};
    unique case (op)
      OPC_RFMT: begin c.rd_dest = 1'b1; c.reg_wr = 1'b1; c.cls = CLS_FUNCT; end
      OPC_LOAD: begin c.imm_op = 1'b1; c.wb_mem = 1'b1; c.reg_wr = 1'b1; c.mem_rd = 1'b1; end
      OPC_STOR: begin c.imm_op = 1'b1; c.mem_wr = 1'b1; end
      OPC_BEQ:  begin c.br = 1'b1; c.cls = CLS_SUB; end
      OPC_JUMP: begin c.jmp = 1'b1; end
      default:  ;
    endcase
    return c;
  endfunction

  function automatic logic [SEL_W-1:0] funct_to_sel(input logic [FN_W-1:0] fn);
    unique case (fn)
      FN_AND:  return SEL_AND;
      FN_OR:   return SEL_OR;
      FN_SUB:  return SEL_SUB;
      FN_SLT:  return SEL_SLT;
      default: return SEL_ADD;
    endcase
  endfunction

  function automatic logic [SEL_W-1:0] class_to_sel(input alu_class_e cls,
                                                    input logic [FN_W-1:0] fn);
    unique case (cls)
      CLS_SUB:   return SEL_SUB;
      CLS_FUNCT: return funct_to_sel(fn);
      default:   return SEL_ADD;
    endcase
  endfunction

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_dec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ctrl_t           ctrl
);

  logic is_rfmt, is_load, is_stor, is_beq, is_jump, is_known;

  assign ctrl     = decode_opcode(op);
  assign is_rfmt  = (op == OPC_RFMT);
  assign is_load  = (op == OPC_LOAD);
  assign is_stor  = (op == OPC_STOR);
  assign is_beq   = (op == OPC_BEQ);
  assign is_jump  = (op == OPC_JUMP);
  assign is_known = is_rfmt | is_load | is_stor | is_beq | is_jump;

  always_comb begin
    if (!$isunknown(op)) begin
      assert_rd_dest_rfmt_R1: assert (ctrl.rd_dest == ~|op)
        else $error("rd_dest disagrees with all-zero opcode");
      assert_load_writes_R2: assert (!ctrl.mem_rd || (ctrl.reg_wr && ctrl.wb_mem))
        else $error("memory read without write-back from memory");
      assert_store_only_R3: assert (!ctrl.mem_wr || (!ctrl.reg_wr && !ctrl.mem_rd))
        else $error("store also writes register or reads memory");
      assert_flow_onehot_R4: assert ($onehot0({ctrl.br, ctrl.jmp, ctrl.mem_wr, ctrl.reg_wr}))
        else $error("more than one of branch/jump/store/regwrite");
      assert_jump_quiet_R5: assert (!ctrl.jmp || ctrl.cls == CLS_ADD)
        else $error("jump with non-add class");
      assert_unknown_idle_R6: assert (is_known || ({ctrl.rd_dest, ctrl.imm_op, ctrl.wb_mem,
                                        ctrl.reg_wr, ctrl.mem_rd, ctrl.mem_wr, ctrl.br,
                                        ctrl.jmp} == '0 && ctrl.cls == CLS_ADD))
        else $error("undecoded opcode raised a control");
      assert_imm_eqn_R11: assert (ctrl.imm_op == (op[5] & ~op[4] & ~op[2] & op[1] & op[0]))
        else $error("imm operand disagrees with bit equation");
    end
  end

endmodule

// File: rtl/ctl_alu_sel.sv
module ctl_alu_sel
  import ctl_dec_pkg::*;
(
  input  alu_class_e       cls,
  input  logic [FN_W-1:0]  fn,
  output logic [SEL_W-1:0] sel
);

  logic fn_listed;

  assign sel       = class_to_sel(cls, fn);
  assign fn_listed = (fn == FN_ADD) | (fn == FN_SUB) | (fn == FN_AND) |
                     (fn == FN_OR)  | (fn == FN_SLT);

  always_comb begin
    if (!$isunknown({cls, fn})) begin
      assert_add_class_R7: assert (cls inside {CLS_FUNCT, CLS_SUB} || sel == SEL_ADD)
        else $error("add class gave non-add select");
      assert_sub_class_R8: assert (cls != CLS_SUB || sel == SEL_SUB)
        else $error("sub class gave non-sub select");
      assert_funct_add_R9: assert (!(cls == CLS_FUNCT && fn == FN_ADD) || sel == SEL_ADD)
        else $error("add funct mis-decoded");
      assert_funct_default_R10: assert (!(cls == CLS_FUNCT && !fn_listed) || sel == SEL_ADD)
        else $error("unlisted funct did not default to add");
    end
  end

endmodule

// File: rtl/insn_ctrl_decoder.sv
module insn_ctrl_decoder
  import ctl_dec_pkg::*;
(
  input  logic [5:0] op_code,
  input  logic [5:0] fn_code,
  output logic       rd_dest,
  output logic       imm_operand,
  output logic       wb_from_mem,
  output logic       reg_wr_en,
  output logic       mem_rd_en,
  output logic       mem_wr_en,
  output logic       br_eq,
  output logic       jmp_take,
  output logic [1:0] alu_class,
  output logic [2:0] alu_op
);

  ctrl_t ctrl_w;

  ctl_main_dec u_main (
    .op   (op_code),
    .ctrl (ctrl_w)
  );

  ctl_alu_sel u_alu (
    .cls (ctrl_w.cls),
    .fn  (fn_code),
    .sel (alu_op)
  );

  assign rd_dest     = ctrl_w.rd_dest;
  assign imm_operand = ctrl_w.imm_op;
  assign wb_from_mem = ctrl_w.wb_mem;
  assign reg_wr_en   = ctrl_w.reg_wr;
  assign mem_rd_en   = ctrl_w.mem_rd;
  assign mem_wr_en   = ctrl_w.mem_wr;
  assign br_eq       = ctrl_w.br;
  assign jmp_take    = ctrl_w.jmp;
  assign alu_class   = ctrl_w.cls;

endmodule

// File: tb/test_insn_ctrl_decoder.sv
module test_insn_ctrl_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] op_code, fn_code;
  logic rd_dest, imm_operand, wb_from_mem, reg_wr_en, mem_rd_en, mem_wr_en, br_eq, jmp_take;
  logic [1:0] alu_class;
  logic [2:0] alu_op;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_ctrl_decoder i_insn_ctrl_decoder (
    .op_code(op_code), .fn_code(fn_code), .rd_dest(rd_dest), .imm_operand(imm_operand),
    .wb_from_mem(wb_from_mem), .reg_wr_en(reg_wr_en), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .br_eq(br_eq), .jmp_take(jmp_take),
    .alu_class(alu_class), .alu_op(alu_op)
  );

  // expected {rd_dest, imm, wb_mem, reg_wr, mem_rd, mem_wr, br, jmp, class[1:0]}
  function automatic logic [9:0] ref_ctrl(input logic [5:0] op);
    if (op == 6'd0)  return 10'b1001000010; // R1
    if (op == 6'd35) return 10'b0111100000; // R2
    if (op == 6'd43) return 10'b0100010000; // R3
    if (op == 6'd4)  return 10'b0000001001; // R4
    if (op == 6'd2)  return 10'b0000000100; // R5
    return 10'b0;                           // R6
  endfunction

  function automatic logic [2:0] ref_sel(input logic [1:0] cls, input logic [5:0] fn);
    if (cls == 2'b01) return 3'b110;        // R8
    if (cls != 2'b10) return 3'b010;        // R7
    if (fn == 6'd36) return 3'b000;         // R9
    if (fn == 6'd37) return 3'b001;
    if (fn == 6'd32) return 3'b010;
    if (fn == 6'd34) return 3'b110;
    if (fn == 6'd42) return 3'b111;
    return 3'b010;                          // R10
  endfunction

  function automatic logic [9:0] got_ctrl();
    return {rd_dest, imm_operand, wb_from_mem, reg_wr_en, mem_rd_en, mem_wr_en,
            br_eq, jmp_take, alu_class};
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(posedge clk);
    op_code = op;
    fn_code = fn;
    @(negedge clk);
  endtask

  task automatic run_pair(input string req, input logic [5:0] op, input logic [5:0] fn);
    logic [9:0] e;
    apply(op, fn);
    e = ref_ctrl(op);
    check(req, got_ctrl(), e);
    check(req, {7'b0, alu_op}, {7'b0, ref_sel(e[1:0], fn)});
  endtask

  task automatic t_reset_state();
    apply(6'd0, 6'd32);
    check("R1 initial", got_ctrl(), 10'b1001000010);
    check("R9 initial", {7'b0, alu_op}, {7'b0, 3'b010});
  endtask

  task automatic t_rfmt_funct();
    logic [5:0] fns [5] = '{6'd36, 6'd37, 6'd32, 6'd34, 6'd42};
    logic [2:0] exp [5] = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111};
    for (int i = 0; i < 5; i++) begin
      apply(6'd0, fns[i]);
      check("R1", got_ctrl(), 10'b1001000010);
      check("R9", {7'b0, alu_op}, {7'b0, exp[i]});
    end
  endtask

  task automatic t_rfmt_unknown_funct();
    logic [5:0] fns [6] = '{6'd0, 6'd33, 6'd38, 6'd43, 6'd10, 6'd63};
    for (int i = 0; i < 6; i++) begin
      apply(6'd0, fns[i]);
      check("R10", {7'b0, alu_op}, {7'b0, 3'b010});
    end
  endtask

  task automatic t_mem_ops();
    foreach (ref_sel_fns[i]) begin
      run_pair("R2 R7", 6'd35, ref_sel_fns[i]);
      run_pair("R3 R7", 6'd43, ref_sel_fns[i]);
    end
  endtask

  task automatic t_branch_jump();
    foreach (ref_sel_fns[i]) begin
      run_pair("R4 R8", 6'd4, ref_sel_fns[i]);
      run_pair("R5 R7", 6'd2, ref_sel_fns[i]);
    end
  endtask

  task automatic t_opcode_sweep();
    for (int op = 0; op < 64; op++) begin
      logic [5:0] o;
      o = 6'(op);
      apply(o, 6'd34);
      check("R6", got_ctrl(), ref_ctrl(o));
      check("R11", {9'b0, imm_operand}, {9'b0, (op == 35 || op == 43)});
      check("R7", {7'b0, alu_op}, {7'b0, ref_sel(ref_ctrl(o) & 2'b11, 6'd34)});
    end
  endtask

  logic [5:0] ref_sel_fns [4] = '{6'd32, 6'd36, 6'd42, 6'd17};

  initial begin
    op_code = '0;
    fn_code = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_rfmt_funct();
    t_rfmt_unknown_funct();
    t_mem_ops();
    t_branch_jump();
    t_opcode_sweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule